// File: doc/BRIEF.md
# Isolated Channel Receive Decoder

This block is the receive half of one data channel that crosses an isolation barrier. The transmit half reports each level change on its input as a short pulse. A rising edge becomes a set pulse and a falling edge becomes a clear pulse. While the input is steady, the transmit half resends its current level as a refresh pulse at a fixed interval. The decoder turns these pulses back into a steady output level, which it keeps between pulses.

A watchdog counts clock cycles that pass with no pulse of either kind. When the count reaches a programmed limit, the decoder assumes the transmit half has lost power, forces the output low and raises a timeout flag. Any later pulse clears the timeout at once.

An output-side supply-good input gates the whole block:
- While it is low, the output is held low and the output driver is released.
- While it is low, the internal state is cleared.
- When it rises again, the output stays low until a real pulse arrives.

An output-enable input releases the driver without changing the decoded level.

Top module: `iso_rx_decoder`

## Requirements
- R1: With the supply good, a set pulse (set_pulse=1, clr_pulse=0) makes dout 1 in the cycle after the edge that samples it.
- R2: With the supply good, a clear pulse makes dout 0 in the cycle after the edge that samples it.
- R3: In a cycle with no pulse, dout keeps its previous value, unless the timeout starts at that edge.
- R4: A set pulse and a clear pulse sampled at the same edge act as a clear, and dout becomes 0.
- R5: After TIMEOUT_CYC consecutive sampling edges with no pulse and the supply good, dout is 0 and timeout_flag is 1. After TIMEOUT_CYC-1 such edges, the flag is still 0.
- R6: Every pulse restarts the idle count, including a refresh pulse that repeats the current level. Pulses spaced at most TIMEOUT_CYC-1 idle edges apart never raise timeout_flag.
- R7: A pulse received while timeout_flag is 1 clears the flag and sets dout from that pulse, both in the next cycle.
- R8: While supply_ok is 0, the following outputs are 0 in the same cycle: dout, dout_oe and timeout_flag.
- R9: After supply_ok rises, dout stays 0 until the first pulse, even if dout was 1 before the supply dropped.
- R10: dout_oe equals supply_ok AND out_en. out_en has no effect on dout.
- R11: When the decoder is fed by a transmit model that refreshes every REFRESH cycles (REFRESH < TIMEOUT_CYC), dout matches the transmitted level within REFRESH+1 cycles of the supply coming up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Output-side supply above lockout |
| out_en | input | 1 | Output driver enable |
| set_pulse | input | 1 | Decoded set pulse, one cycle per event |
| clr_pulse | input | 1 | Decoded clear pulse, one cycle per event |
| dout | output | 1 | Recovered channel level |
| dout_oe | output | 1 | Driver enable; 0 means high impedance |
| timeout_flag | output | 1 | Watchdog is currently forcing the output low |

## Verification
The hardest case to reach is the boundary of the idle window. The stimulus runs exactly TIMEOUT_CYC-1 idle edges and checks that the flag has not risen. It then runs one more idle edge and checks that the flag has risen. It also refreshes at the last legal edge for several rounds, so the output stays high without ever expiring. The second hard case is a supply drop while the output is high. The stimulus drops the supply, raises it again and idles, so that any state left over from before the drop would show on dout. A behavioural transmit model then drives the decoder through another supply cycle, checking that the output recovers from refresh pulses alone.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

   // 5 us at a 125 MHz receive clock
   localparam int RXDEC_DEF_TIMEOUT = 625;

   typedef enum logic [0:0] {
      PRIO_CLR = 1'b0,
      PRIO_SET = 1'b1
   } prio_e;

   function automatic logic next_level(input logic cur, input logic s,
                                       input logic c, input prio_e prio);
      logic nxt;
      nxt = cur;
      if (s && c)  nxt = (prio == PRIO_SET);
      else if (c)  nxt = 1'b0;
      else if (s)  nxt = 1'b1;
      return nxt;
   endfunction

endpackage

// File: rtl/rxdec_watchdog.sv
module rxdec_watchdog #(
   parameter int TIMEOUT_CYC = rxdec_pkg::RXDEC_DEF_TIMEOUT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic kick,
   output logic expired
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("rxdec_watchdog: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] idle_cnt;
   logic             exp_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         exp_r    <= 1'b0;
      end else if (!enable || kick) begin
         idle_cnt <= '0;
         exp_r    <= 1'b0;
      end else if (!exp_r) begin
         if (idle_cnt == LAST) exp_r    <= 1'b1;
         else                  idle_cnt <= idle_cnt + 1'b1;
      end
   end

   assign expired = exp_r;
endmodule

// File: rtl/rxdec_level.sv
module rxdec_level #(
   parameter rxdec_pkg::prio_e PRIO = rxdec_pkg::PRIO_CLR
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic set_i,
   input  logic clr_i,
   output logic level
);
   logic lvl_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_r <= 1'b0;
      else if (!enable) lvl_r <= 1'b0;
      else              lvl_r <= rxdec_pkg::next_level(lvl_r, set_i, clr_i, PRIO);
   end

   assign level = lvl_r;
endmodule

// File: rtl/rxdec_outstage.sv
module rxdec_outstage #(
   parameter bit HAS_OE = 1'b1
) (
   input  logic supply_ok,
   input  logic out_en,
   input  logic level,
   input  logic expired,
   output logic dout,
   output logic dout_oe,
   output logic timeout_flag
);
   assign dout         = supply_ok & level & ~expired;
   assign timeout_flag = supply_ok & expired;

   generate
      if (HAS_OE) begin : g_oe
         assign dout_oe = supply_ok & out_en;
      end else begin : g_no_oe
         logic unused_en;
         assign unused_en = out_en;
         assign dout_oe   = supply_ok;
      end
   endgenerate
endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder #(
   parameter int               TIMEOUT_CYC = rxdec_pkg::RXDEC_DEF_TIMEOUT,
   parameter rxdec_pkg::prio_e PRIO        = rxdec_pkg::PRIO_CLR,
   parameter bit               HAS_OE      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic out_en,
   input  logic set_pulse,
   input  logic clr_pulse,
   output logic dout,
   output logic dout_oe,
   output logic timeout_flag
);
   logic any_pulse;
   logic level;
   logic expired;

   assign any_pulse = set_pulse | clr_pulse;

   rxdec_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (supply_ok),
      .kick    (any_pulse),
      .expired (expired)
   );

   rxdec_level #(.PRIO(PRIO)) u_level (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (supply_ok),
      .set_i  (set_pulse),
      .clr_i  (clr_pulse),
      .level  (level)
   );

   rxdec_outstage #(.HAS_OE(HAS_OE)) u_out (
      .supply_ok    (supply_ok),
      .out_en       (out_en),
      .level        (level),
      .expired      (expired),
      .dout         (dout),
      .dout_oe      (dout_oe),
      .timeout_flag (timeout_flag)
   );
endmodule

// File: rtl/iso_rx_decoder_chk.sv
module iso_rx_decoder_chk #(
   parameter int TIMEOUT_CYC = rxdec_pkg::RXDEC_DEF_TIMEOUT
) (
   input logic clk,
   input logic rst_n,
   input logic supply_ok,
   input logic out_en,
   input logic set_pulse,
   input logic clr_pulse,
   input logic dout,
   input logic dout_oe,
   input logic timeout_flag
);
   int idle_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               idle_run <= 0;
      else if (!supply_ok || set_pulse || clr_pulse) idle_run <= 0;
      else if (idle_run < TIMEOUT_CYC)          idle_run <= idle_run + 1;
   end

   // R1
   set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok && set_pulse && !clr_pulse |=> dout || !supply_ok);

   // R2
   clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok && clr_pulse |=> !dout);

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok && !set_pulse && !clr_pulse |=> !supply_ok || timeout_flag || $stable(dout));

   // R4
   both_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok && set_pulse && clr_pulse |=> !dout);

   // R5
   expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      supply_ok && idle_run >= TIMEOUT_CYC |-> timeout_flag && !dout);

   // R6
   no_early_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_flag |-> idle_run >= TIMEOUT_CYC);

   // R8
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |-> !dout && !dout_oe && !timeout_flag);

   // R9
   powerup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(supply_ok) |-> !dout);

   // R10
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !dout_oe);
endmodule

bind iso_rx_decoder iso_rx_decoder_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (.*);

// File: tb/iso_rx_decoder_test.sv
`timescale 1ns/1ps
module iso_rx_decoder_test;
   localparam int TMO     = 40;
   localparam int REFRESH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0;
   logic out_en = 1'b1;
   logic set_pulse = 1'b0;
   logic clr_pulse = 1'b0;
   logic dout, dout_oe, timeout_flag;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;
   string phase = "R3";

   // behavioural reference
   bit m_lvl = 1'b0;
   bit m_exp = 1'b0;
   int m_idle = 0;

   // transmit model state
   bit enc_last = 1'b0;
   int enc_idle = 0;

   always #4 clk = ~clk;

   iso_rx_decoder #(.TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .out_en(out_en),
      .set_pulse(set_pulse), .clr_pulse(clr_pulse),
      .dout(dout), .dout_oe(dout_oe), .timeout_flag(timeout_flag)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lvl = 1'b0; m_exp = 1'b0; m_idle = 0;
      end else if (!supply_ok) begin
         m_lvl = 1'b0; m_exp = 1'b0; m_idle = 0;
      end else if (set_pulse || clr_pulse) begin
         m_lvl = !clr_pulse; m_exp = 1'b0; m_idle = 0;
      end else if (!m_exp) begin
         m_idle++;
         if (m_idle == TMO) m_exp = 1'b1;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
      #2;
      if (rst_n) begin
         check({phase, " dout"}, dout, supply_ok & m_lvl & ~m_exp);
         check("R10 oe", dout_oe, supply_ok & out_en);
         check({phase, " flag"}, timeout_flag, supply_ok & m_exp);
      end
   end

   task automatic cyc(input logic s, input logic c);
      @(negedge clk);
      set_pulse = s; clr_pulse = c;
      @(posedge clk); #2;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
   endtask

   task automatic enc_cyc(input logic d);
      if (d != enc_last) begin
         enc_last = d; enc_idle = 0;
         cyc(d, ~d);
      end else if (enc_idle == REFRESH - 1) begin
         enc_idle = 0;
         cyc(d, ~d);
      end else begin
         enc_idle++;
         cyc(1'b0, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R8 reset dout", dout, 1'b0);
      check("R8 reset oe", dout_oe, 1'b0);
      check("R8 reset flag", timeout_flag, 1'b0);
      @(negedge clk); rst_n = 1'b1; supply_ok = 1'b1;

      phase = "R9";
      idle(5);
      check("R9 low before first pulse", dout, 1'b0);

      phase = "R1"; cyc(1, 0); check("R1 set", dout, 1'b1);
      phase = "R3"; idle(6);   check("R3 hold high", dout, 1'b1);
      phase = "R2"; cyc(0, 1); check("R2 clr", dout, 1'b0);
      phase = "R3"; idle(4);   check("R3 hold low", dout, 1'b0);
      phase = "R1"; cyc(1, 0);
      phase = "R4"; cyc(1, 1); check("R4 both acts as clear", dout, 1'b0);

      phase = "R6";
      cyc(1, 0);
      for (int r = 0; r < 3; r++) begin
         idle(TMO - 1);
         check("R6 no expiry at last idle edge", timeout_flag, 1'b0);
         cyc(1, 0);
      end
      check("R6 refreshed level", dout, 1'b1);

      phase = "R5";
      idle(TMO - 1);
      check("R5 flag not yet", timeout_flag, 1'b0);
      check("R5 level held", dout, 1'b1);
      idle(1);
      check("R5 flag raised", timeout_flag, 1'b1);
      check("R5 forced low", dout, 1'b0);
      idle(3);

      phase = "R7";
      cyc(1, 0);
      check("R7 flag cleared", timeout_flag, 1'b0);
      check("R7 pulse applied", dout, 1'b1);

      phase = "R10";
      @(negedge clk); out_en = 1'b0;
      @(posedge clk); #2;
      check("R10 oe off", dout_oe, 1'b0);
      check("R10 level unaffected", dout, 1'b1);
      @(negedge clk); out_en = 1'b1;

      phase = "R8";
      @(negedge clk); supply_ok = 1'b0; #1;
      check("R8 dout low same cycle", dout, 1'b0);
      check("R8 oe off same cycle", dout_oe, 1'b0);
      idle(4);
      @(negedge clk); supply_ok = 1'b1;
      phase = "R9";
      idle(8);
      check("R9 low after supply return", dout, 1'b0);

      phase = "R11";
      enc_last = dout; enc_idle = 0;
      for (int i = 0; i < 12; i++) enc_cyc(1'b1);
      for (int i = 0; i < 30; i++) enc_cyc(i[2]);
      @(negedge clk); supply_ok = 1'b0;
      for (int i = 0; i < 5; i++) enc_cyc(1'b1);
      @(negedge clk); supply_ok = 1'b1;
      for (int i = 0; i < REFRESH + 1; i++) enc_cyc(1'b1);
      check("R11 follows tx after power-up", dout, 1'b1);

      phase = "R5";
      idle(TMO);
      check("R5 tx silent then low", dout, 1'b0);
      check("R5 tx silent flag", timeout_flag, 1'b1);

      idle(2);
      finish_run();
   end
endmodule